// File: doc/BRIEF.md
# Half-Duplex SPI Slave Byte Engine

This block is the serial front end of a host-access port. It acts as an SPI slave in mode 0 and gives a register or FIFO block behind it a byte-level view of each transfer. The host frames a transfer with an active-low chip select. Incoming bits arrive most significant first and are grouped into bytes. Each complete byte is handed to the system clock domain with a strobe, and the first byte of each transfer carries a command flag.

When the first byte of a transfer completes, the internal logic may answer with a read indication. The rest of that transfer then runs in the output direction. Before each following byte, the engine loads a byte from the internal logic into its shifter and asks for the next one. It drives the data line only in this phase. At all other times the output enable stays low, so that a tristate cell at the top level can release the line.

The serial logic runs directly on the serial clock and on chip select. Completed bytes and transmit requests reach the system clock through toggle synchronizers. If chip select rises in the middle of a byte, the partial byte is dropped.

Top module: `spi_byte_slave`

## Requirements
- R1: SI is sampled on rising SCK edges, and eight consecutive samples form one byte, the first sample being bit 7 of `rx_data`.
- R2: Each complete byte of a write transfer produces exactly one single-cycle `rx_valid` pulse in the `clk` domain, with the byte on `rx_data`. Back-to-back bytes under one chip-select low period each produce their own pulse, in order.
- R3: `rx_first` is 1 with the first byte received after `cs_n` falls and 0 with every later byte of the same transfer.
- R4: If `cs_n` rises after fewer than eight rising SCK edges of a byte, that byte produces no `rx_valid` pulse, and the next transfer starts counting again at bit 7.
- R5: If `rd_mode` is 1 at the rising SCK edge that completes the first byte, every later byte of the transfer is transmitted. On the following falling SCK edge, `tx_data` is loaded into the shifter. SO then carries bit 7 before the first rising edge of the outgoing byte and moves to the next lower bit on each falling edge.
- R6: Each load of `tx_data` produces exactly one single-cycle `tx_req` pulse in the `clk` domain. The next load takes whatever `tx_data` holds at that time, so bytes go out in the order the internal logic supplies them.
- R7: While the engine is transmitting, SI is ignored and no `rx_valid` pulse occurs.
- R8: `so_oe` is 0 whenever `cs_n` is 1 and throughout write transfers. It is 1 while a read transfer shifts out data.
- R9: With `rst_n` at 0, `rx_valid`, `tx_req` and `so_oe` are 0, with no clock needed.
- R10: `rd_mode` is looked at only when the first byte completes. A 1 on it when a later byte of a write transfer completes leaves that transfer in the input direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the strobes and captured data |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock, idles low |
| cs_n | input | 1 | Active-low chip select that frames a transfer |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Enable for the tristate buffer that drives SO |
| rx_valid | output | 1 | One-cycle strobe: a complete byte has been received |
| rx_data | output | W | Received byte |
| rx_first | output | 1 | Received byte is the first of its transfer |
| rd_mode | input | 1 | Internal logic marks the transfer as a read |
| tx_data | input | W | Next byte to transmit |
| tx_req | output | 1 | One-cycle strobe: `tx_data` was taken, supply the next byte |

## Verification
One rising SCK edge does two jobs at once. It completes the command byte, which must be strobed out with the first flag, and it decides the read direction that takes effect on the very next falling edge. The read scenario provokes this edge. It is judged by two results: exactly one received byte with the flag set, and the first reply byte appearing MSB first on SO before the next rising edge. The same scenario also shows that SI activity during reply bytes produces no received strobes. The write scenario then raises `rd_mode` while a later byte completes, to show that the direction decision is not taken a second time.

// File: rtl/spi_byte_slave.sv
module spi_byte_slave #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sck,
  input  logic         cs_n,
  input  logic         si,
  output logic         so,
  output logic         so_oe,
  output logic         rx_valid,
  output logic [W-1:0] rx_data,
  output logic         rx_first,
  input  logic         rd_mode,
  input  logic [W-1:0] tx_data,
  output logic         tx_req
);
  localparam int CW = $clog2(W);

  logic          sck_rst;
  logic [CW-1:0] cnt;
  logic [W-2:0]  sh;
  logic          seen_cmd, in_read;
  logic [W-1:0]  rx_hold;
  logic          rx_first_h, rx_tog;
  logic [W-1:0]  tx_sh;
  logic          oe, tx_tog;
  logic [2:0]    rxs, txs;
  logic          byte_end, rx_take, tx_load;

  assign sck_rst  = cs_n | ~rst_n;
  assign byte_end = (cnt == CW'(W-1));
  assign rx_take  = ~in_read & byte_end;
  assign tx_load  = in_read & (cnt == '0);
  assign so       = tx_sh[W-1];
  assign so_oe    = oe & ~cs_n;

  always_ff @(posedge sck or posedge sck_rst) begin
    if (sck_rst) begin
      cnt      <= '0;
      sh       <= '0;
      seen_cmd <= 1'b0;
      in_read  <= 1'b0;
    end else begin
      cnt <= byte_end ? '0 : cnt + CW'(1);
      if (!in_read) sh <= {sh[W-3:0], si};
      if (rx_take) begin
        seen_cmd <= 1'b1;
        if (!seen_cmd && rd_mode) in_read <= 1'b1;
      end
    end
  end

  always_ff @(posedge sck or negedge rst_n) begin
    if (!rst_n) begin
      rx_hold    <= '0;
      rx_first_h <= 1'b0;
      rx_tog     <= 1'b0;
    end else if (rx_take) begin
      rx_hold    <= {sh, si};
      rx_first_h <= ~seen_cmd;
      rx_tog     <= ~rx_tog;
    end
  end

  always_ff @(negedge sck or posedge sck_rst) begin
    if (sck_rst) begin
      tx_sh <= '0;
      oe    <= 1'b0;
    end else if (tx_load) begin
      tx_sh <= tx_data;
      oe    <= 1'b1;
    end else if (oe) begin
      tx_sh <= {tx_sh[W-2:0], 1'b0};
    end
  end

  always_ff @(negedge sck or negedge rst_n) begin
    if (!rst_n)       tx_tog <= 1'b0;
    else if (tx_load) tx_tog <= ~tx_tog;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxs      <= '0;
      txs      <= '0;
      rx_valid <= 1'b0;
      tx_req   <= 1'b0;
      rx_data  <= '0;
      rx_first <= 1'b0;
    end else begin
      rxs      <= {rxs[1:0], rx_tog};
      txs      <= {txs[1:0], tx_tog};
      rx_valid <= rxs[2] ^ rxs[1];
      tx_req   <= txs[2] ^ txs[1];
      if (rxs[2] ^ rxs[1]) begin
        rx_data  <= rx_hold;
        rx_first <= rx_first_h;
      end
    end
  end

  AST_RX_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R2
  AST_TXREQ_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |=> !tx_req); // R6
  AST_NO_RX_WHILE_READ: assert property (@(posedge sck) disable iff (sck_rst)
    in_read |=> $stable(rx_tog)); // R7
  AST_OE_ONLY_READ: assert property (@(negedge sck) disable iff (sck_rst)
    so_oe |-> in_read); // R8
  AST_FIRST_ONCE: assert property (@(posedge sck) disable iff (sck_rst)
    (rx_take && seen_cmd) |=> !rx_first_h); // R3
endmodule

// File: tb/tb_spi_byte_slave.sv
`timescale 1ns/1ps
module tb_spi_byte_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0;
  logic cs_n = 1'b1;
  logic si = 1'b0;
  logic rd_mode = 1'b0;
  logic so, so_oe, rx_valid, rx_first, tx_req;
  logic [7:0] rx_data, tx_data;
  logic [7:0] txq [16];
  logic [7:0] rx_d [64];
  logic       rx_f [64];
  int rx_n = 0, txr_n = 0, oe_n = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  assign tx_data = txq[txr_n[3:0]];

  spi_byte_slave #(.W(8)) dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .so(so), .so_oe(so_oe), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_first(rx_first), .rd_mode(rd_mode), .tx_data(tx_data), .tx_req(tx_req)
  );

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (rx_valid) begin
      rx_d[rx_n[5:0]] = rx_data;
      rx_f[rx_n[5:0]] = rx_first;
      rx_n++;
    end
    if (tx_req) txr_n++;
    if (so_oe) oe_n++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] got);
    for (int i = 7; i >= 0; i--) begin
      si = b[i];
      #40 got[i] = so;
      sck = 1'b1;
      #50 sck = 1'b0;
      #10;
    end
  endtask

  task automatic bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      si = b[i];
      #40 sck = 1'b1;
      #50 sck = 1'b0;
      #10;
    end
  endtask

  task automatic cs_low;  #50 cs_n = 1'b0; #50; endtask
  task automatic cs_high; #50 cs_n = 1'b1; #300; endtask

  task automatic t_reset;
    #1;
    check(rx_valid == 1'b0, "R9 rx_valid", rx_valid, 0);
    check(tx_req == 1'b0, "R9 tx_req", tx_req, 0);
    check(so_oe == 1'b0, "R9 so_oe", so_oe, 0);
  endtask

  task automatic t_write;
    logic [7:0] g;
    int b = rx_n, o = oe_n;
    cs_low();
    xfer(8'hA5, g); xfer(8'h3C, g); xfer(8'hFF, g);
    cs_high();
    check(rx_n - b == 3, "R2 byte count", rx_n - b, 3);
    check(rx_d[b] == 8'hA5, "R1 byte0", rx_d[b], 8'hA5);
    check(rx_d[b+1] == 8'h3C, "R2 byte1", rx_d[b+1], 8'h3C);
    check(rx_d[b+2] == 8'hFF, "R2 byte2", rx_d[b+2], 8'hFF);
    check(rx_f[b] == 1'b1, "R3 first flag", rx_f[b], 1);
    check(rx_f[b+1] == 1'b0 && rx_f[b+2] == 1'b0, "R3 later flags", rx_f[b+1], 0);
    check(oe_n == o, "R8 oe in write", oe_n - o, 0);
  endtask

  task automatic t_partial;
    logic [7:0] g;
    int b = rx_n;
    cs_low();
    xfer(8'h81, g);
    bits(8'hF0, 5);
    cs_high();
    check(rx_n - b == 1, "R4 partial dropped", rx_n - b, 1);
    check(rx_d[b] == 8'h81, "R4 full byte kept", rx_d[b], 8'h81);
    cs_low();
    xfer(8'h5A, g);
    cs_high();
    check(rx_n - b == 2, "R4 next count", rx_n - b, 2);
    check(rx_d[b+1] == 8'h5A && rx_f[b+1], "R4 realigned", rx_d[b+1], 8'h5A);
  endtask

  task automatic t_read;
    logic [7:0] g;
    int b = rx_n, t = txr_n;
    txq[(t) % 16] = 8'hC3;
    txq[(t + 1) % 16] = 8'h96;
    txq[(t + 2) % 16] = 8'h11;
    txq[(t + 3) % 16] = 8'h00;
    txq[(t + 4) % 16] = 8'h00;
    rd_mode = 1'b1;
    cs_low();
    xfer(8'h80, g);
    rd_mode = 1'b0;
    xfer(8'hFF, g);
    check(g == 8'hC3, "R5 first reply byte", g, 8'hC3);
    check(so_oe == 1'b1, "R8 oe in read", so_oe, 1);
    xfer(8'h00, g);
    check(g == 8'h96, "R6 second reply byte", g, 8'h96);
    xfer(8'hA5, g);
    check(g == 8'h11, "R6 third reply byte", g, 8'h11);
    cs_high();
    check(so_oe == 1'b0, "R8 oe after cs", so_oe, 0);
    check(rx_n - b == 1 && rx_f[b], "R7 only command received", rx_n - b, 1);
    check(rx_d[b] == 8'h80, "R1 command byte", rx_d[b], 8'h80);
    check(txr_n - t == 4, "R6 request count", txr_n - t, 4);
  endtask

  task automatic t_late_rd;
    logic [7:0] g;
    int b = rx_n, o = oe_n;
    rd_mode = 1'b0;
    cs_low();
    xfer(8'h12, g);
    rd_mode = 1'b1;
    xfer(8'h34, g); xfer(8'h56, g);
    rd_mode = 1'b0;
    cs_high();
    check(rx_n - b == 3 && rx_d[b+2] == 8'h56, "R10 late rd_mode ignored", rx_n - b, 3);
    check(oe_n == o, "R10 no output", oe_n - o, 0);
  endtask

  task automatic t_async_reset;
    rst_n = 1'b0;
    #1;
    check(rx_valid == 0 && tx_req == 0 && so_oe == 0, "R9 async reset", so_oe, 0);
    #20 rst_n = 1'b1;
    #20;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) txq[i] = 8'h00;
    #20;
    t_reset();
    rst_n = 1'b1;
    #20;
    t_write();
    t_partial();
    t_read();
    t_late_rd();
    t_async_reset();
    t_write();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule